// File: doc/BRIEF.md
# Two-Wire Slave Command Decoder

This block is the serial front end of a four-channel register device that sits on an open-drain two-wire bus. It oversamples the clock and data lines in the system clock domain and finds start and stop conditions. It accepts a device address made of a fixed type nibble and four strap pins, then an instruction byte that names an operation, one of four registers and one of four channels. It answers each byte with an acknowledge by pulling the data line low during the ninth clock.

Depending on the operation, the command ends after the instruction byte (transfers), continues with one data byte written by the master or sent by the slave, or opens an increment/decrement stream in which each further clock pulse moves a wiper by one step. Accepted commands leave the block as single-cycle strobes with the decoded fields, for a register bank and a set of wiper counters to act on. A busy input from the nonvolatile store makes the block refuse its address, so that a master can poll until an internal write has finished.

Top module: `tw_cmd_slave`

## Requirements
- R1: While reset is high and after it is released, `sda_oe` is low and neither `cmd_stb` nor `step_stb` pulses until a command is accepted.
- R2: A start (data falls while clock is high) at any point restarts the address phase; a stop (data rises while clock is high) returns the block to idle and drops a partly received command without any strobe.
- R3: The first byte after a start is taken most significant bit first; it is acknowledged only if bits 7..4 equal 0101 and bits 3..0 equal `strap_addr`; otherwise `sda_oe` stays low for the rest of the transfer until the next start.
- R4: When `nv_busy` is high at the end of the address byte, the address is not acknowledged, even if it matches.
- R5: The instruction byte holds the operation code in bits 7..4, the register select in bits 3..2 and the channel select in bits 1..0. Codes 1001, 1010, 1011, 1100, 1101, 1110, 0001, 1000 and 0010 are acknowledged; any other code is not acknowledged, gives no strobe and leaves the block silent until the next start.
- R6: Transfer codes 1101, 1110, 0001 and 1000 give one `cmd_stb` when their instruction byte is accepted, with `cmd_op`, `cmd_reg` and `cmd_chan` taken from that byte, and `cmd_data` unchanged.
- R7: Write codes 1010 (wiper) and 1100 (data register) take a third byte of the form 0 0 D5..D0, acknowledge it and give one `cmd_stb` with `cmd_data` equal to D5..D0.
- R8: Read codes 1001 and 1011 make the slave send 0 0 D5..D0, most significant bit first, where D5..D0 is `rd_data` sampled at the end of the instruction acknowledge; the slave releases the line for the master's acknowledge and gives no strobe.
- R9: After code 0010 is accepted, each following clock pulse gives one `step_stb` on its falling edge, with `step_up` equal to the data level while the clock was high; a stop or start ends the stream with no extra step.
- R10: `cmd_stb` and `step_stb` are single-cycle pulses and never high together.
- R11: The slave only starts pulling the data line while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| strap_addr | input | 4 | Strap pins giving the low address nibble |
| nv_busy | input | 1 | Nonvolatile write in progress |
| rd_data | input | 6 | Value of the selected register for reads |
| cmd_stb | output | 1 | One-cycle strobe of an accepted command |
| cmd_op | output | 4 | Operation code of the last accepted instruction |
| cmd_reg | output | 2 | Register select of the last accepted instruction |
| cmd_chan | output | 2 | Channel select of the last accepted instruction |
| cmd_data | output | 6 | Data of the last write command |
| step_stb | output | 1 | One-cycle strobe of a wiper step |
| step_up | output | 1 | Step direction, high for up |

## Verification
A wrong phase or bit count inside the block shows as an acknowledge in the wrong ninth clock or a read bit on the wrong pulse, visible on `sda_oe` within a few system clocks of the bus clock falling edge. A decoding fault shows as a missing, extra or mis-fielded strobe, observed by the end of the same transfer. The reference model in the bench predicts the data line drive for every settled bus phase and the full list of strobes per transfer, so a fault is reported at the first phase or transfer where it appears.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int BYTE_W = 8;
    localparam int DATA_W = 6;
    localparam int SEL_W  = 2;
    localparam int OPC_W  = 4;
    localparam int PAD_W  = BYTE_W - DATA_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [OPC_W-1:0] DEV_TYPE_DEF = 4'b0101;

    typedef enum logic [OPC_W-1:0] {
        OPC_GXFR_D2W = 4'b0001,
        OPC_STEP     = 4'b0010,
        OPC_GXFR_W2D = 4'b1000,
        OPC_RD_WIPER = 4'b1001,
        OPC_WR_WIPER = 4'b1010,
        OPC_RD_DATA  = 4'b1011,
        OPC_WR_DATA  = 4'b1100,
        OPC_XFR_D2W  = 4'b1101,
        OPC_XFR_W2D  = 4'b1110
    } opc_e;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_XFR,
        CL_WRITE,
        CL_READ,
        CL_STEP
    } opc_class_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INSTR,
        PH_WDATA,
        PH_RDATA,
        PH_STEP
    } phase_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [SEL_W-1:0] rsel;
        logic [SEL_W-1:0] csel;
    } instr_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic opc_class_e classify(input logic [OPC_W-1:0] code);
        opc_class_e cls;
        case (code)
            OPC_XFR_D2W, OPC_XFR_W2D,
            OPC_GXFR_D2W, OPC_GXFR_W2D: cls = CL_XFR;
            OPC_WR_WIPER, OPC_WR_DATA:  cls = CL_WRITE;
            OPC_RD_WIPER, OPC_RD_DATA:  cls = CL_READ;
            OPC_STEP:                   cls = CL_STEP;
            default:                    cls = CL_NONE;
        endcase
        return cls;
    endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events
    import tw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/tw_cmd_engine.sv
module tw_cmd_engine
    import tw_pkg::*;
#(
    parameter logic [OPC_W-1:0] DEV_TYPE = DEV_TYPE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [OPC_W-1:0]  strap_addr,
    input  logic              nv_busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              cmd_stb,
    output logic [OPC_W-1:0]  cmd_op,
    output logic [SEL_W-1:0]  cmd_reg,
    output logic [SEL_W-1:0]  cmd_chan,
    output logic [DATA_W-1:0] cmd_data,
    output logic              step_stb,
    output logic              step_up
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    phase_e            ph;
    phase_e            nxt;
    logic [CNT_W-1:0]  cnt;
    logic              in_ack;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic              step_dir;

    instr_t            rx_instr;
    opc_class_e        dec_cls;
    logic              dec_ok;
    phase_e            dec_nxt;
    logic [BYTE_W-1:0] rd_word;

    assign rx_instr = instr_t'(sh);
    assign rd_word  = {{PAD_W{1'b0}}, rd_data};

    // Decision taken when a received byte is complete
    always_comb begin
        dec_cls = classify(rx_instr.opc);
        dec_ok  = 1'b0;
        dec_nxt = PH_IDLE;
        case (ph)
            PH_ADDR: begin
                dec_ok  = (sh[BYTE_W-1 -: OPC_W] == DEV_TYPE) &&
                          (sh[OPC_W-1:0] == strap_addr) && !nv_busy;
                dec_nxt = dec_ok ? PH_INSTR : PH_IDLE;
            end
            PH_INSTR: begin
                dec_ok = (dec_cls != CL_NONE);
                case (dec_cls)
                    CL_WRITE: dec_nxt = PH_WDATA;
                    CL_READ:  dec_nxt = PH_RDATA;
                    CL_STEP:  dec_nxt = PH_STEP;
                    default:  dec_nxt = PH_IDLE;
                endcase
            end
            PH_WDATA: begin
                dec_ok  = 1'b1;
                dec_nxt = PH_IDLE;
            end
            default: begin
                dec_ok  = 1'b0;
                dec_nxt = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            nxt      <= PH_IDLE;
            cnt      <= '0;
            in_ack   <= 1'b0;
            sh       <= '0;
            tx       <= '0;
            step_dir <= 1'b0;
            sda_oe   <= 1'b0;
            cmd_stb  <= 1'b0;
            cmd_op   <= '0;
            cmd_reg  <= '0;
            cmd_chan <= '0;
            cmd_data <= '0;
            step_stb <= 1'b0;
            step_up  <= 1'b0;
        end else begin
            cmd_stb  <= 1'b0;
            step_stb <= 1'b0;
            if (ev.start) begin
                ph     <= PH_ADDR;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                ph     <= PH_IDLE;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (ph)
                    PH_ADDR, PH_INSTR, PH_WDATA: begin
                        if (ev.scl_rise && !in_ack && cnt != CNT_FULL) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end
                        if (ev.scl_fall) begin
                            if (in_ack) begin
                                in_ack <= 1'b0;
                                cnt    <= '0;
                                sda_oe <= 1'b0;
                                ph     <= nxt;
                                if (nxt == PH_RDATA) begin
                                    tx     <= rd_word;
                                    sda_oe <= ~rd_word[BYTE_W-1];
                                end
                            end else if (cnt == CNT_FULL) begin
                                in_ack <= 1'b1;
                                sda_oe <= dec_ok;
                                nxt    <= dec_nxt;
                                if (ph == PH_INSTR && dec_ok) begin
                                    cmd_op   <= rx_instr.opc;
                                    cmd_reg  <= rx_instr.rsel;
                                    cmd_chan <= rx_instr.csel;
                                    if (dec_cls == CL_XFR) begin
                                        cmd_stb <= 1'b1;
                                    end
                                end
                                if (ph == PH_WDATA) begin
                                    cmd_data <= sh[DATA_W-1:0];
                                    cmd_stb  <= 1'b1;
                                end
                            end
                        end
                    end
                    PH_RDATA: begin
                        if (ev.scl_rise && !in_ack && cnt != CNT_FULL) begin
                            cnt <= cnt + 1'b1;
                        end
                        if (ev.scl_fall) begin
                            if (in_ack) begin
                                in_ack <= 1'b0;
                                ph     <= PH_IDLE;
                            end else if (cnt == CNT_FULL) begin
                                in_ack <= 1'b1;
                                sda_oe <= 1'b0;
                            end else if (cnt != '0) begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    PH_STEP: begin
                        if (ev.scl_rise) begin
                            step_dir <= ev.sda;
                        end
                        if (ev.scl_fall) begin
                            step_stb <= 1'b1;
                            step_up  <= step_dir;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/tw_cmd_slave.sv
module tw_cmd_slave
    import tw_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [OPC_W-1:0] DEV_TYPE    = DEV_TYPE_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [3:0]  strap_addr,
    input  logic        nv_busy,
    input  logic [5:0]  rd_data,
    output logic        cmd_stb,
    output logic [3:0]  cmd_op,
    output logic [1:0]  cmd_reg,
    output logic [1:0]  cmd_chan,
    output logic [5:0]  cmd_data,
    output logic        step_stb,
    output logic        step_up
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_s;
    bus_ev_t            ev;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        tw_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b1)
        ) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (line_raw[g]),
            .q   (line_s[g])
        );
    end

    tw_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_s (line_s[0]),
        .sda_s (line_s[1]),
        .ev    (ev)
    );

    tw_cmd_engine #(
        .DEV_TYPE (DEV_TYPE)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .strap_addr (strap_addr),
        .nv_busy    (nv_busy),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .cmd_stb    (cmd_stb),
        .cmd_op     (cmd_op),
        .cmd_reg    (cmd_reg),
        .cmd_chan   (cmd_chan),
        .cmd_data   (cmd_data),
        .step_stb   (step_stb),
        .step_up    (step_up)
    );
endmodule

// File: rtl/tw_cmd_slave_chk.sv
module tw_cmd_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       cmd_stb,
    input logic [3:0] cmd_op,
    input logic       step_stb
);
    // R1: reset leaves the bus released and no strobes
    a_r1_quiet_reset: assert property (@(posedge clk)
        rst |=> (!sda_oe && !cmd_stb && !step_stb));

    // R11: the slave starts pulling only while the clock line is low
    a_r11_pull_on_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    // R10: command strobe lasts one cycle
    a_r10_stb_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |=> !cmd_stb);

    // R10: never both strobes together
    a_r10_stb_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_stb, step_stb}));

    // R6, R7: only write and transfer operations are strobed
    a_r6_stb_legal_op: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> (cmd_op inside {4'b1010, 4'b1100, 4'b1101,
                                    4'b1110, 4'b0001, 4'b1000}));

    // R9: step strobe lasts one cycle
    a_r9_step_pulse: assert property (@(posedge clk) disable iff (rst)
        step_stb |=> !step_stb);
endmodule

bind tw_cmd_slave tw_cmd_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .cmd_stb  (cmd_stb),
    .cmd_op   (cmd_op),
    .step_stb (step_stb)
);

// File: tb/tw_cmd_slave_bench.sv
module tw_cmd_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PH_LEN     = 12;
    localparam int SETTLE     = 5;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] strap = 4'b0110;
    logic       nv_busy = 1'b0;
    logic [5:0] rd_data;

    logic       sda_oe;
    logic       cmd_stb;
    logic [3:0] cmd_op;
    logic [1:0] cmd_reg;
    logic [1:0] cmd_chan;
    logic [5:0] cmd_data;
    logic       step_stb;
    logic       step_up;
    logic       sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic  exp_known = 1'b0;
    logic  exp_oe = 1'b0;
    string cur_req = "R1";

    logic [14:0] got_q[$];
    logic [14:0] exp_q[$];
    logic [5:0]  last_data = 6'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    function automatic logic [5:0] rd_fn(input logic [1:0] r, input logic [1:0] c);
        return {r, ~c, c};
    endfunction

    assign rd_data = rd_fn(cmd_reg, cmd_chan);

    tw_cmd_slave u_tw_cmd_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .strap_addr (strap),
        .nv_busy    (nv_busy),
        .rd_data    (rd_data),
        .cmd_stb    (cmd_stb),
        .cmd_op     (cmd_op),
        .cmd_reg    (cmd_reg),
        .cmd_chan   (cmd_chan),
        .cmd_data   (cmd_data),
        .step_stb   (step_stb),
        .step_up    (step_up)
    );

    function automatic logic [14:0] mk_cmd(input logic [3:0] op, input logic [1:0] r,
                                           input logic [1:0] c, input logic [5:0] d);
        return {1'b0, op, r, c, d};
    endfunction

    function automatic logic [14:0] mk_step(input logic up);
        return {1'b1, 13'd0, up};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // Reference drive of the data line, compared in every settled phase
    always @(negedge clk) begin
        if (!rst && exp_known && !done) begin
            check(cur_req, 32'(sda_oe), 32'(exp_oe));
        end
    end

    // Strobe monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_stb)  got_q.push_back({1'b0, cmd_op, cmd_reg, cmd_chan, cmd_data});
            if (step_stb) got_q.push_back(mk_step(step_up));
        end
    end

    task automatic phase(input logic c, input logic d, input logic oe, input string req);
        exp_known = 1'b0;
        scl_m = c;
        sda_m = d;
        repeat (SETTLE) @(negedge clk);
        exp_oe    = oe;
        cur_req   = req;
        exp_known = 1'b1;
        repeat (PH_LEN - SETTLE) @(negedge clk);
        exp_known = 1'b0;
    endtask

    task automatic pulse(input logic d, input logic oe, input string req);
        phase(1'b0, sda_m, oe, req);
        phase(1'b0, d, oe, req);
        phase(1'b1, d, oe, req);
    endtask

    task automatic bus_start();
        if (!(scl_m && sda_m)) begin
            phase(1'b0, sda_m, 1'b0, "R2");
            phase(1'b0, 1'b1, 1'b0, "R2");
        end
        phase(1'b1, 1'b1, 1'b0, "R2");
        phase(1'b1, 1'b0, 1'b0, "R2");
    endtask

    task automatic bus_stop();
        phase(1'b0, sda_m, 1'b0, "R2");
        phase(1'b0, 1'b0, 1'b0, "R2");
        phase(1'b1, 1'b0, 1'b0, "R2");
        phase(1'b1, 1'b1, 1'b0, "R2");
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack, input string req);
        for (int i = 7; i >= 0; i--) pulse(b[i], 1'b0, req);
        pulse(1'b1, ack, req);
    endtask

    task automatic read_byte(input logic [5:0] d, input string req);
        logic [7:0] w;
        w = {2'b00, d};
        for (int i = 7; i >= 0; i--) pulse(1'b1, ~w[i], req);
        pulse(1'b1, 1'b0, req);
    endtask

    task automatic check_queue(input string req);
        check(req, 32'(got_q.size()), 32'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            check(req, 32'(got_q[i]), 32'(exp_q[i]));
        end
        got_q.delete();
        exp_q.delete();
    endtask

    function automatic logic [7:0] addr_byte();
        return {4'b0101, strap};
    endfunction

    task automatic do_write(input logic [3:0] op, input logic [1:0] r, input logic [1:0] c,
                            input logic [5:0] d, input string req);
        bus_start();
        send_byte(addr_byte(), 1'b1, "R3");
        send_byte({op, r, c}, 1'b1, "R5");
        send_byte({2'b00, d}, 1'b1, req);
        bus_stop();
        last_data = d;
        exp_q.push_back(mk_cmd(op, r, c, d));
        check_queue(req);
    endtask

    task automatic do_xfr(input logic [3:0] op, input logic [1:0] r, input logic [1:0] c);
        bus_start();
        send_byte(addr_byte(), 1'b1, "R3");
        send_byte({op, r, c}, 1'b1, "R6");
        bus_stop();
        exp_q.push_back(mk_cmd(op, r, c, last_data));
        check_queue("R6");
    endtask

    task automatic do_read(input logic [3:0] op, input logic [1:0] r, input logic [1:0] c);
        bus_start();
        send_byte(addr_byte(), 1'b1, "R3");
        send_byte({op, r, c}, 1'b1, "R5");
        read_byte(rd_fn(r, c), "R8");
        bus_stop();
        check_queue("R8");
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1", 32'(sda_oe), 0);
        check("R1", 32'(cmd_stb), 0);
        check("R1", 32'(step_stb), 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check("R1", 32'(sda_oe), 0);
        check("R1", 32'(cmd_stb | step_stb), 0);

        // R7: writes to wiper and data register
        do_write(4'b1010, 2'b00, 2'b10, 6'h2A, "R7");
        do_write(4'b1100, 2'b11, 2'b01, 6'h15, "R7");

        // R8: reads
        do_read(4'b1001, 2'b00, 2'b11);
        do_read(4'b1011, 2'b10, 2'b01);

        // R6: transfers, single and global
        do_xfr(4'b1101, 2'b10, 2'b00);
        do_xfr(4'b1110, 2'b01, 2'b11);
        do_xfr(4'b0001, 2'b11, 2'b00);
        do_xfr(4'b1000, 2'b10, 2'b00);

        // R3: wrong type nibble, block stays silent
        bus_start();
        send_byte({4'b0100, strap}, 1'b0, "R3");
        send_byte({4'b1101, 4'b0000}, 1'b0, "R3");
        bus_stop();
        check_queue("R3");

        // R3: wrong strap value
        bus_start();
        send_byte({4'b0101, strap ^ 4'b0001}, 1'b0, "R3");
        send_byte({4'b1110, 4'b0101}, 1'b0, "R3");
        bus_stop();
        check_queue("R3");

        // R3: new strap value is honoured
        strap = 4'b1001;
        do_xfr(4'b1101, 2'b01, 2'b10);

        // R4: busy polling
        nv_busy = 1'b1;
        bus_start();
        send_byte(addr_byte(), 1'b0, "R4");
        bus_stop();
        check_queue("R4");
        nv_busy = 1'b0;
        bus_start();
        send_byte(addr_byte(), 1'b1, "R4");
        bus_stop();
        check_queue("R4");

        // R5: undefined opcode
        bus_start();
        send_byte(addr_byte(), 1'b1, "R3");
        send_byte({4'b0011, 2'b01, 2'b01}, 1'b0, "R5");
        send_byte({2'b00, 6'h3F}, 1'b0, "R5");
        bus_stop();
        check_queue("R5");

        // R9: increment / decrement stream
        bus_start();
        send_byte(addr_byte(), 1'b1, "R3");
        send_byte({4'b0010, 2'b00, 2'b11}, 1'b1, "R9");
        pulse(1'b1, 1'b0, "R9");
        pulse(1'b1, 1'b0, "R9");
        pulse(1'b1, 1'b0, "R9");
        pulse(1'b0, 1'b0, "R9");
        bus_stop();
        exp_q.push_back(mk_step(1'b1));
        exp_q.push_back(mk_step(1'b1));
        exp_q.push_back(mk_step(1'b1));
        exp_q.push_back(mk_step(1'b0));
        check_queue("R9");

        // R2: repeated start in the middle of an instruction byte
        bus_start();
        send_byte(addr_byte(), 1'b1, "R3");
        pulse(1'b1, 1'b0, "R2");
        pulse(1'b0, 1'b0, "R2");
        pulse(1'b1, 1'b0, "R2");
        pulse(1'b0, 1'b0, "R2");
        bus_start();
        send_byte(addr_byte(), 1'b1, "R2");
        send_byte({4'b1110, 2'b10, 2'b01}, 1'b1, "R2");
        bus_stop();
        exp_q.push_back(mk_cmd(4'b1110, 2'b10, 2'b01, last_data));
        check_queue("R2");

        // R2: stop in the middle of a data byte drops the write
        bus_start();
        send_byte(addr_byte(), 1'b1, "R3");
        send_byte({4'b1010, 2'b00, 2'b01}, 1'b1, "R5");
        pulse(1'b0, 1'b0, "R2");
        pulse(1'b0, 1'b1 & 1'b0, "R2");
        pulse(1'b1, 1'b0, "R2");
        bus_stop();
        check_queue("R2");

        // R7: write with value at the top of the range after the abort
        do_write(4'b1010, 2'b00, 2'b01, 6'h3F, "R7");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule